// File: doc/BRIEF.md
# Paged PHY Register Access Sequencer

This block carries out one register access to an Ethernet PHY whose vendor-defined registers are banked behind a page-select register. A requester supplies a PHY address, a register number, a page number, a direction flag and write data. The block locks the shared management bus with a request/grant handshake. For a banked register it then reads and keeps the current page, writes the requested page, performs the access, and writes the kept page back. Only after that does it release the lock. Other software-visible state on the PHY is therefore left as it was, and no other master can slip a transaction in between the steps.

Registers below the standard boundary (0 to 15) are never banked. A request for one of them, or for the page-select register itself, becomes a single direct transaction under the same lock. The number of the page-select register comes from a configuration input.

The block drives a frame-level management transaction port: start, op, PHY address, register address, write data, read data and done. A separate serializer turns each transaction into bus bits. Completion is signalled to the requester with a one-cycle pulse, and read data is returned alongside it.

Top module: `phy_page_seq`

## Requirements
- R1: After reset, busy, bus_req, mgmt_start and resp_done are all low.
- R2: A request is taken only in a cycle where req_valid is high and busy is low. A req_valid pulse while busy is ignored: it starts no transaction and changes no PHY register.
- R3: Once a request is taken, bus_req rises. No management transaction starts while bus_gnt is low, however long the grant is withheld.
- R4: A request whose register number is 16 or above, and is not cfg_page_reg, issues exactly four transactions in this order: a read of cfg_page_reg, a write of the requested page (zero-extended) to cfg_page_reg, the target access, and a write of the value read in the first step back to cfg_page_reg.
- R5: A request to register 0 to 15, or to cfg_page_reg itself, issues exactly one transaction: the access itself, to the given register.
- R6: After any request other than a direct write to cfg_page_reg, the PHY's page-select register holds the value it held before the request.
- R7: bus_req stays high from the start of the first transaction until the final transaction has completed, so another master cannot be granted the bus while a sequence is in progress.
- R8: For a read (req_write low), resp_rdata equals the data returned by the target access, not the data from the page save or the restore.
- R9: A write (req_write high) stores req_wdata in the target register of the requested page. Direct registers are written in place.
- R10: resp_done is a one-cycle pulse. It comes after bus_req has dropped and bus_gnt has gone low, and busy is low in the same cycle.
- R11: mgmt_start is a one-cycle pulse. No transaction starts while an earlier one still awaits mgmt_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_page_reg | input | 5 | Register number of the page-select register |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register number |
| req_page | input | 8 | Page to select for banked registers |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A request is in progress |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read data of the last read request |
| bus_req | output | 1 | Management bus lock request |
| bus_gnt | input | 1 | Management bus lock grant |
| mgmt_start | output | 1 | Starts one frame-level transaction |
| mgmt_write | output | 1 | Transaction op: 1 = write, 0 = read |
| mgmt_phy | output | 5 | Transaction PHY address |
| mgmt_reg | output | 5 | Transaction register address |
| mgmt_wdata | output | 16 | Transaction write data |
| mgmt_rdata | input | 16 | Transaction read data, valid with mgmt_done |
| mgmt_done | input | 1 | Transaction complete |

## Verification
The bench builds the block with its default parameters: 5-bit PHY and register numbers, 16-bit data, 8-bit page numbers and a boundary of 16 unbanked registers. Its PHY model has eight banks on four addresses, so reads and writes to the same register number in different pages can be told apart. The page-select register number is moved from 31 to 20 partway through the run. This shows that the old number becomes an ordinary banked register and the new one becomes a direct one. A second master on the bench arbiter makes it possible to hold off the grant before a sequence and to attempt a grab during one.

// File: rtl/phy_page_pkg.sv
// Package: shared phase and step encodings for the paged PHY sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package phy_page_pkg;

    // Top-level phase of a request
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOCK   = 2'd1,
        PH_XFER   = 2'd2,
        PH_UNLOCK = 2'd3
    } pps_phase_e;

    // Transaction step within PH_XFER; order is the issue order
    typedef enum logic [1:0] {
        ST_SAVE    = 2'd0,
        ST_SELECT  = 2'd1,
        ST_ACCESS  = 2'd2,
        ST_RESTORE = 2'd3
    } pps_step_e;

endpackage

// File: rtl/pps_req_latch.sv
// Module: pps_req_latch
// Holds the accepted request, the page value saved from the PHY and the
// read result. Assumes capture is only raised while the sequencer is idle.
module pps_req_latch #(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int PAGE_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              in_paged,
    input  logic              in_write,
    input  logic [PHY_W-1:0]  in_phy,
    input  logic [REG_W-1:0]  in_reg,
    input  logic [REG_W-1:0]  in_page_reg,
    input  logic [PAGE_W-1:0] in_page,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              save_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] xact_rdata,
    output logic              paged_q,
    output logic              write_q,
    output logic [PHY_W-1:0]  phy_q,
    output logic [REG_W-1:0]  reg_q,
    output logic [REG_W-1:0]  page_reg_q,
    output logic [PAGE_W-1:0] page_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] saved_page_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Capture all request fields together at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paged_q    <= 1'b0;
            write_q    <= 1'b0;
            phy_q      <= '0;
            reg_q      <= '0;
            page_reg_q <= '0;
            page_q     <= '0;
            wdata_q    <= '0;
        end else if (capture) begin
            paged_q    <= in_paged;
            write_q    <= in_write;
            phy_q      <= in_phy;
            reg_q      <= in_reg;
            page_reg_q <= in_page_reg;
            page_q     <= in_page;
            wdata_q    <= in_wdata;
        end
    end

    // Keep the page value read before it is overwritten
    always_ff @(posedge clk) begin
        if (!rst_n)       saved_page_q <= '0;
        else if (save_en) saved_page_q <= xact_rdata;
    end

    // Keep the result of the target read until the next one
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= xact_rdata;
    end

    // R2: request fields only change on acceptance
    a_r2_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(reg_q) && $stable(phy_q) && $stable(write_q) && $stable(wdata_q)));

endmodule

// File: rtl/pps_xact_fmt.sv
// Module: pps_xact_fmt
// Builds the fields of the current management transaction from the step.
// Assumes DATA_W > PAGE_W so the page number is zero-extended.
module pps_xact_fmt #(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int PAGE_W = 8,
    parameter int DATA_W = 16
) (
    input  phy_page_pkg::pps_step_e step,
    input  logic              write_q,
    input  logic [PHY_W-1:0]  phy_q,
    input  logic [REG_W-1:0]  reg_q,
    input  logic [REG_W-1:0]  page_reg_q,
    input  logic [PAGE_W-1:0] page_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] saved_page_q,
    output logic              x_write,
    output logic [PHY_W-1:0]  x_phy,
    output logic [REG_W-1:0]  x_reg,
    output logic [DATA_W-1:0] x_wdata
);
    import phy_page_pkg::*;

    localparam int PAD_W = DATA_W - PAGE_W;

    logic [DATA_W-1:0] page_ext;
    assign page_ext = {{PAD_W{1'b0}}, page_q};
    assign x_phy    = phy_q;

    // Select op, register and data for the current step
    always_comb begin
        unique case (step)
            ST_SAVE: begin
                x_write = 1'b0;
                x_reg   = page_reg_q;
                x_wdata = '0;
            end
            ST_SELECT: begin
                x_write = 1'b1;
                x_reg   = page_reg_q;
                x_wdata = page_ext;
            end
            ST_ACCESS: begin
                x_write = write_q;
                x_reg   = reg_q;
                x_wdata = wdata_q;
            end
            default: begin
                x_write = 1'b1;
                x_reg   = page_reg_q;
                x_wdata = saved_page_q;
            end
        endcase
    end

endmodule

// File: rtl/pps_ctrl.sv
// Module: pps_ctrl
// Sequencer: lock, up to four transactions, unlock, completion pulse.
// Assumes the management port raises mgmt_done once per started
// transaction, at least one cycle after the start.
module pps_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic in_paged,
    input  logic paged_q,
    input  logic write_q,
    input  logic bus_gnt,
    input  logic mgmt_done,
    output phy_page_pkg::pps_step_e step,
    output logic capture,
    output logic busy,
    output logic bus_req,
    output logic mgmt_start,
    output logic save_en,
    output logic rd_en,
    output logic resp_done
);
    import phy_page_pkg::*;

    pps_phase_e phase;
    logic       inflight;
    logic       done_q;
    logic       xact_end;

    assign capture    = req_valid && (phase == PH_IDLE);
    assign busy       = (phase != PH_IDLE);
    assign bus_req    = (phase == PH_LOCK) || (phase == PH_XFER);
    assign mgmt_start = (phase == PH_XFER) && !inflight;
    assign xact_end   = (phase == PH_XFER) && inflight && mgmt_done;
    assign save_en    = xact_end && (step == ST_SAVE);
    assign rd_en      = xact_end && (step == ST_ACCESS) && !write_q;
    assign resp_done  = done_q;

    // Phase and step progression
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            step     <= ST_ACCESS;
            inflight <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (mgmt_start) inflight <= 1'b1;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase <= PH_LOCK;
                        step  <= in_paged ? ST_SAVE : ST_ACCESS;
                    end
                end
                PH_LOCK: begin
                    if (bus_gnt) phase <= PH_XFER;
                end
                PH_XFER: begin
                    if (xact_end) begin
                        inflight <= 1'b0;
                        unique case (step)
                            ST_SAVE:   step <= ST_SELECT;
                            ST_SELECT: step <= ST_ACCESS;
                            ST_ACCESS: begin
                                if (paged_q) step  <= ST_RESTORE;
                                else         phase <= PH_UNLOCK;
                            end
                            default:   phase <= PH_UNLOCK;
                        endcase
                    end
                end
                default: begin
                    if (!bus_gnt) begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R3: no transaction without the lock
    a_r3_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_start |-> (bus_gnt && bus_req));

    // R11: start is a single-cycle pulse
    a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_start |=> !mgmt_start);

    // R7: the lock is only dropped right after a transaction completes
    a_r7_lock_until_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(mgmt_done));

    // R10: completion is a single pulse with the block idle and unlocked
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> (!busy && !bus_req && !bus_gnt));

endmodule

// File: rtl/phy_page_seq.sv
// Module: phy_page_seq (top)
// Paged PHY register access sequencer. Wraps one request in a locked
// save/select/access/restore series of management transactions, or a
// single direct access for unbanked registers and the page register.
// Assumes DATA_W > PAGE_W and STD_REGS < 2**REG_W.
module phy_page_seq #(
    parameter int PHY_W    = 5,
    parameter int REG_W    = 5,
    parameter int PAGE_W   = 8,
    parameter int DATA_W   = 16,
    parameter int STD_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  cfg_page_reg,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              resp_done,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mgmt_start,
    output logic              mgmt_write,
    output logic [PHY_W-1:0]  mgmt_phy,
    output logic [REG_W-1:0]  mgmt_reg,
    output logic [DATA_W-1:0] mgmt_wdata,
    input  logic [DATA_W-1:0] mgmt_rdata,
    input  logic              mgmt_done
);
    import phy_page_pkg::*;

    localparam logic [REG_W-1:0] FIRST_BANKED = REG_W'(STD_REGS);

    logic              in_paged;
    logic              capture, save_en, rd_en;
    logic              paged_q, write_q;
    logic [PHY_W-1:0]  phy_q;
    logic [REG_W-1:0]  reg_q, page_reg_q;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] wdata_q, saved_page_q;
    pps_step_e         step;

    // Banked target: above the standard set and not the page register
    assign in_paged = (req_reg >= FIRST_BANKED) && (req_reg != cfg_page_reg);

    pps_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .in_paged   (in_paged),
        .paged_q    (paged_q),
        .write_q    (write_q),
        .bus_gnt    (bus_gnt),
        .mgmt_done  (mgmt_done),
        .step       (step),
        .capture    (capture),
        .busy       (busy),
        .bus_req    (bus_req),
        .mgmt_start (mgmt_start),
        .save_en    (save_en),
        .rd_en      (rd_en),
        .resp_done  (resp_done)
    );

    pps_req_latch #(
        .PHY_W (PHY_W), .REG_W (REG_W), .PAGE_W (PAGE_W), .DATA_W (DATA_W)
    ) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .in_paged     (in_paged),
        .in_write     (req_write),
        .in_phy       (req_phy),
        .in_reg       (req_reg),
        .in_page_reg  (cfg_page_reg),
        .in_page      (req_page),
        .in_wdata     (req_wdata),
        .save_en      (save_en),
        .rd_en        (rd_en),
        .xact_rdata   (mgmt_rdata),
        .paged_q      (paged_q),
        .write_q      (write_q),
        .phy_q        (phy_q),
        .reg_q        (reg_q),
        .page_reg_q   (page_reg_q),
        .page_q       (page_q),
        .wdata_q      (wdata_q),
        .saved_page_q (saved_page_q),
        .rdata_q      (resp_rdata)
    );

    pps_xact_fmt #(
        .PHY_W (PHY_W), .REG_W (REG_W), .PAGE_W (PAGE_W), .DATA_W (DATA_W)
    ) u_fmt (
        .step         (step),
        .write_q      (write_q),
        .phy_q        (phy_q),
        .reg_q        (reg_q),
        .page_reg_q   (page_reg_q),
        .page_q       (page_q),
        .wdata_q      (wdata_q),
        .saved_page_q (saved_page_q),
        .x_write      (mgmt_write),
        .x_phy        (mgmt_phy),
        .x_reg        (mgmt_reg),
        .x_wdata      (mgmt_wdata)
    );

    // R4: the restore writes back exactly the page read by the save
    a_r4_restore_saved: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_start && step == ST_RESTORE) |-> (mgmt_write && mgmt_reg == page_reg_q
                                                && mgmt_wdata == saved_page_q));

endmodule

// File: tb/phy_page_seq_tb.sv
// Bench for phy_page_seq: PHY model with banked registers, two-master
// arbiter, and a scoreboard fed by the driver and drained at completion.
module phy_page_seq_tb;

    localparam int NPHY = 4;
    localparam int NPG  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_page_reg = 5'd31;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_phy = '0, req_reg = '0;
    logic [7:0]  req_page = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, resp_done, bus_req, bus_gnt;
    logic [15:0] resp_rdata;
    logic        mgmt_start, mgmt_write, mgmt_done;
    logic [4:0]  mgmt_phy, mgmt_reg;
    logic [15:0] mgmt_wdata, mgmt_rdata;
    logic        other_req = 1'b0, other_gnt;

    int errors = 0, checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    phy_page_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_page_reg(cfg_page_reg),
        .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
        .req_reg(req_reg), .req_page(req_page), .req_wdata(req_wdata),
        .busy(busy), .resp_done(resp_done), .resp_rdata(resp_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mgmt_start(mgmt_start), .mgmt_write(mgmt_write), .mgmt_phy(mgmt_phy),
        .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
        .mgmt_done(mgmt_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- arbiter: 0 none, 1 dut, 2 other ----------------
    int owner;
    always @(posedge clk) begin
        if (!rst_n) owner <= 0;
        else case (owner)
            0: if (bus_req) owner <= 1; else if (other_req) owner <= 2;
            1: if (!bus_req) owner <= 0;
            default: if (!other_req) owner <= 0;
        endcase
    end
    assign bus_gnt   = (owner == 1);
    assign other_gnt = (owner == 2);

    // ---------------- PHY model ----------------
    logic [15:0] m_std  [NPHY][16];
    logic [15:0] m_bank [NPHY][NPG][16];
    logic [15:0] m_pg   [NPHY];
    logic [15:0] e_std  [NPHY][16];
    logic [15:0] e_bank [NPHY][NPG][16];
    logic [15:0] e_pg   [NPHY];

    function automatic logic [15:0] init_val(int p, int g, int r);
        return 16'((p << 12) | (g << 8) | (r * 5 + 3));
    endfunction

    int mdl_cnt = 0, xact_cnt = 0, viol_grant = 0, viol_overlap = 0, viol_other = 0;
    logic [4:0] trace_reg[$];
    always @(posedge clk) begin
        mgmt_done <= 1'b0;
        if (!rst_n) begin
            mdl_cnt = 0;
            mgmt_rdata <= '0;
        end else if (mgmt_start) begin
            automatic int p = int'(mgmt_phy[1:0]);
            automatic int r = int'(mgmt_reg);
            automatic int g = int'(m_pg[p][2:0]);
            if (!bus_gnt) viol_grant++;
            if (mdl_cnt != 0) viol_overlap++;
            if (other_gnt) viol_other++;
            xact_cnt++;
            trace_reg.push_back(mgmt_reg);
            if (mgmt_write) begin
                if (mgmt_reg == cfg_page_reg) m_pg[p] = mgmt_wdata;
                else if (r < 16) m_std[p][r] = mgmt_wdata;
                else m_bank[p][g][r-16] = mgmt_wdata;
            end else begin
                if (mgmt_reg == cfg_page_reg) mgmt_rdata <= m_pg[p];
                else if (r < 16) mgmt_rdata <= m_std[p][r];
                else mgmt_rdata <= m_bank[p][g][r-16];
            end
            mdl_cnt = 3;
        end else if (mdl_cnt != 0) begin
            if (mdl_cnt == 1) mgmt_done <= 1'b1;
            mdl_cnt = mdl_cnt - 1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          rd;
        bit          paged;
        logic [15:0] data;
        int          xacts;
        int          phy;
        int          rg;
        int          page;
        logic [15:0] pg_after;
    } item_t;
    item_t sb[$];

    // Monitor: compare each completion with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && resp_done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10 unexpected completion", 1, 0);
            end else begin
                automatic item_t it = sb.pop_front();
                chk(!busy && !bus_req, "R10 done with block idle", {busy, bus_req}, 0);
                chk(xact_cnt == it.xacts, it.paged ? "R4 transaction count" : "R5 transaction count",
                    xact_cnt, it.xacts);
                if (it.paged && trace_reg.size() == 4)
                    chk(trace_reg[0] == cfg_page_reg && trace_reg[1] == cfg_page_reg &&
                        trace_reg[2] == 5'(it.rg) && trace_reg[3] == cfg_page_reg,
                        "R4 register order", trace_reg[2], it.rg);
                chk(m_pg[it.phy] == it.pg_after, "R6 page register after request",
                    m_pg[it.phy], it.pg_after);
                if (it.rd)
                    chk(resp_rdata == it.data, "R8 read data", resp_rdata, it.data);
                else if (it.paged)
                    chk(m_bank[it.phy][it.page][it.rg-16] == it.data, "R9 banked write",
                        m_bank[it.phy][it.page][it.rg-16], it.data);
                else if (5'(it.rg) != cfg_page_reg)
                    chk(m_std[it.phy][it.rg] == it.data, "R9 direct write",
                        m_std[it.phy][it.rg], it.data);
            end
            xact_cnt = 0;
            trace_reg.delete();
        end
    end

    // Driver: push expected item, then pulse the request for one cycle
    task automatic send(input bit wr, input int p, input int r, input int g, input logic [15:0] wd,
                        input bit wait_done = 1'b1);
        item_t it;
        while (busy) @(negedge clk);
        it.rd    = !wr;
        it.paged = (r >= 16) && (5'(r) != cfg_page_reg);
        it.xacts = it.paged ? 4 : 1;
        it.phy   = p;
        it.rg    = r;
        it.page  = g;
        if (wr) begin
            it.data = wd;
            if (5'(r) == cfg_page_reg) e_pg[p] = wd;
            else if (r < 16) e_std[p][r] = wd;
            else e_bank[p][g][r-16] = wd;
        end else begin
            if (5'(r) == cfg_page_reg) it.data = e_pg[p];
            else if (r < 16) it.data = e_std[p][r];
            else it.data = e_bank[p][g][r-16];
        end
        it.pg_after = e_pg[p];
        sb.push_back(it);
        req_valid = 1'b1; req_write = wr; req_phy = 5'(p); req_reg = 5'(r);
        req_page = 8'(g); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (wait_done) while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic run_all();
        for (int p = 0; p < NPHY; p++) begin
            m_pg[p] = 16'(p + 1); e_pg[p] = 16'(p + 1);
            for (int r = 0; r < 16; r++) begin
                m_std[p][r] = init_val(p, 15, r); e_std[p][r] = init_val(p, 15, r);
                for (int g = 0; g < NPG; g++) begin
                    m_bank[p][g][r] = init_val(p, g, r); e_bank[p][g][r] = init_val(p, g, r);
                end
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !bus_req && !mgmt_start && !resp_done, "R1 reset outputs",
            {busy, bus_req, mgmt_start, resp_done}, 0);

        // R5/R8: direct reads and writes
        send(0, 0, 3, 0, '0);
        send(1, 1, 7, 5, 16'h1234);
        send(0, 1, 7, 2, '0);
        // R4/R8/R9: banked reads in different pages of the same register
        send(0, 2, 18, 0, '0);
        send(0, 2, 18, 6, '0);
        send(1, 2, 18, 6, 16'hBEEF);
        send(0, 2, 18, 6, '0);
        send(0, 2, 18, 0, '0);
        send(1, 3, 31 - 1, 7, 16'h0F0F);
        send(0, 3, 30, 7, '0);
        // R5: page register read and direct write
        send(0, 0, 31, 0, '0);
        send(1, 0, 31, 0, 16'h0004);
        send(0, 0, 20, 4, '0);

        // R2: request while busy is ignored
        send(0, 1, 25, 3, '0, 1'b0);
        @(negedge clk);
        chk(busy, "R2 block busy during sequence", busy, 1);
        req_valid = 1'b1; req_write = 1'b1; req_phy = 5'd1; req_reg = 5'd9; req_wdata = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (2) @(negedge clk);
        chk(!busy && xact_cnt == 0, "R2 ignored request starts nothing", xact_cnt, 0);
        send(0, 1, 9, 0, '0);

        // R3: grant withheld by another master
        other_req = 1'b1;
        repeat (2) @(negedge clk);
        send(1, 2, 22, 3, 16'h5A5A, 1'b0);
        repeat (20) @(negedge clk);
        chk(busy && bus_req && xact_cnt == 0, "R3 no transaction without grant", xact_cnt, 0);
        other_req = 1'b0;
        wait_idle();
        send(0, 2, 22, 3, '0);

        // R7: another master tries to grab the bus mid-sequence
        send(0, 3, 17, 2, '0, 1'b0);
        other_req = 1'b1;
        wait_idle();
        repeat (3) @(negedge clk);
        chk(other_gnt, "R7 other master granted after release", other_gnt, 1);
        other_req = 1'b0;
        repeat (2) @(negedge clk);

        // R4/R5: move the page register to 20
        cfg_page_reg = 5'd20;
        send(0, 0, 20, 0, '0);
        send(0, 0, 31, 4, '0);
        send(1, 0, 31, 1, 16'h7777);
        send(0, 0, 31, 1, '0);
        send(0, 0, 31, 4, '0);

        chk(viol_grant == 0, "R3 transaction without grant", viol_grant, 0);
        chk(viol_overlap == 0, "R11 overlapping transactions", viol_overlap, 0);
        chk(viol_other == 0, "R7 transaction while other master granted", viol_other, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule